// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps one status byte for every transmission the MAC reports as finished. The bytes wait in a small store of parameterised depth and the host reads them through a single status port. The port always presents the oldest unread byte. Any write to the port discards that byte and moves the next one up. If a completion arrives while the store is full, the block records the loss by setting an overflow flag in the newest stored byte, and the completion itself is not stored.

The block also supervises the transmitter's run state. Commands turn the transmitter on, turn it off, or reset it. A completion that reports jabber or underrun is fatal. So is a TX FIFO overrun, which also raises an adapter-failure flag. After a fatal condition the transmitter is forced off and stays off until a reset command. A reset command empties the store, clears every fatal condition and leaves the transmitter off. Completions that carry an error, or that asked for an interrupt on success, produce a one-cycle interrupt pulse.

Top module: `txcs_top`

## Requirements
- R1: Each stored byte is built from its completion as follows: bit 7 is 1, bit 6 copies the interrupt-request input, bit 5 is jabber, bit 4 is underrun, bit 3 is maximum collisions, bit 2 is overflow (0 when the entry is written), and bits 1..0 are always 0.
- R2: `stat_byte` shows the oldest unread entry. A one-cycle `stat_wr` pulse removes that entry. A `stat_wr` on an empty store has no effect.
- R3: While the store is empty, `stat_byte` reads 0x00, so bit 7 is clear.
- R4: The store holds DEPTH entries (default 4). A completion arriving when the store is full and no write occurs in the same cycle is dropped, and bit 2 of the newest entry is set. A write and a completion in the same cycle on a full store remove the oldest entry and store the new one.
- R5: `txc_irq` is high for exactly the one cycle after a completion that has jabber, underrun, maximum collisions or the interrupt request set. A completion with none of these leaves it low.
- R6: A completion with jabber or underrun forces `tx_on` low from the next cycle. Enable commands are then ignored until a reset command.
- R7: A `fifo_ovr` pulse sets `adapter_fail` and forces `tx_on` low from the next cycle. Only a reset command (code 2 or 3) clears it. An enable command does not.
- R8: A command is accepted when `cmd_vld` is high and is selected by `cmd_code`: 0 enables the transmitter (when no fatal condition holds), 1 disables it, 2 is a transmitter reset and 3 is a global reset.
- R9: A reset command empties the store, clears the fatal and adapter-failure conditions and leaves `tx_on` low. A completion or write in the same cycle as the reset is discarded, and no interrupt results.
- R10: After `rst_n` is released the store is empty, `tx_on`, `adapter_fail` and `txc_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| done_vld | input | 1 | Completion event from the MAC, one cycle |
| done_jab | input | 1 | Completion reports jabber |
| done_und | input | 1 | Completion reports underrun |
| done_maxcoll | input | 1 | Completion reports maximum collisions |
| done_irq_req | input | 1 | Completion asked for interrupt on success |
| stat_wr | input | 1 | Host write to the status port (pop) |
| cmd_vld | input | 1 | Command strobe |
| cmd_code | input | 2 | Command: 0 enable, 1 disable, 2 TX reset, 3 global reset |
| fifo_ovr | input | 1 | TX FIFO overrun event |
| stat_byte | output | 8 | Oldest unread status byte, 0x00 when empty |
| txc_irq | output | 1 | Transmit-complete interrupt pulse |
| tx_on | output | 1 | Transmitter enabled |
| adapter_fail | output | 1 | Adapter failure from TX FIFO overrun |

## Verification
Two functions can coincide in one cycle: the host draining an entry and the MAC delivering a new completion. The bench fills the store to DEPTH and then raises `stat_wr` and `done_vld` on the same clock. It then drains every entry and expects the oldest entry gone, the new byte last, and no overflow bit anywhere. It also pairs a reset command with a completion in one cycle and expects an empty store and no interrupt pulse.

// File: rtl/txcs_pkg.sv
package txcs_pkg;

    typedef enum logic [1:0] {
        CMD_TX_ON  = 2'd0,
        CMD_TX_OFF = 2'd1,
        CMD_TX_RST = 2'd2,
        CMD_ALL_RST = 2'd3
    } txcs_cmd_e;

    localparam int BIT_DONE = 7;
    localparam int BIT_IRQ  = 6;
    localparam int BIT_JAB  = 5;
    localparam int BIT_UND  = 4;
    localparam int BIT_MAXC = 3;
    localparam int BIT_OVF  = 2;

    typedef struct packed {
        logic jab;
        logic und;
        logic maxc;
        logic irq_req;
    } txcs_evt_t;

endpackage

// File: rtl/txcs_fmt.sv
module txcs_fmt
    import txcs_pkg::*;
(
    input  txcs_evt_t  evt,
    output logic [7:0] byte_o,
    output logic       wants_irq,
    output logic       is_fatal
);
    always_comb begin
        byte_o           = '0;
        byte_o[BIT_DONE] = 1'b1;
        byte_o[BIT_IRQ]  = evt.irq_req;
        byte_o[BIT_JAB]  = evt.jab;
        byte_o[BIT_UND]  = evt.und;
        byte_o[BIT_MAXC] = evt.maxc;
        wants_irq        = evt.jab | evt.und | evt.maxc | evt.irq_req;
        is_fatal         = evt.jab | evt.und;
    end
endmodule

// File: rtl/txcs_store.sv
module txcs_store
    import txcs_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       push,
    input  logic [7:0] push_byte,
    input  logic       pop,
    output logic [7:0] top_byte
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [PTR_W-1:0]      rd;
        logic [PTR_W-1:0]      wr;
        logic [CNT_W-1:0]      cnt;
    } st_t;

    st_t st_d, st_q;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PTR_W-1:0] back(input logic [PTR_W-1:0] p);
        return (p == '0) ? PTR_W'(DEPTH - 1) : p - 1'b1;
    endfunction

    logic full, empty, pop_eff, take;

    always_comb begin
        st_d    = st_q;
        empty   = (st_q.cnt == '0);
        full    = (st_q.cnt == CNT_W'(DEPTH));
        pop_eff = pop && !empty;
        take    = push && (!full || pop_eff);
        if (clr) begin
            st_d = '0;
        end else begin
            if (pop_eff) begin
                st_d.rd = step(st_q.rd);
            end
            if (take) begin
                st_d.mem[st_q.wr] = push_byte;
                st_d.wr           = step(st_q.wr);
            end else if (push) begin
                st_d.mem[back(st_q.wr)][BIT_OVF] = 1'b1;
            end
            st_d.cnt = st_q.cnt + CNT_W'(take) - CNT_W'(pop_eff);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign top_byte = empty ? 8'h00 : st_q.mem[st_q.rd];
endmodule

// File: rtl/txcs_ctrl.sv
module txcs_ctrl
    import txcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic cmd_on,
    input  logic cmd_off,
    input  logic evt_vld,
    input  logic evt_irq,
    input  logic evt_fatal,
    input  logic fifo_ovr,
    output logic tx_on,
    output logic fail,
    output logic irq
);
    typedef struct packed {
        logic on;
        logic fatal;
        logic fail;
        logic irq;
    } ctl_t;

    ctl_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (clr) begin
            c_d = '0;
        end else begin
            c_d.irq = evt_vld && evt_irq;
            if (evt_vld && evt_fatal) c_d.fatal = 1'b1;
            if (fifo_ovr)             c_d.fail  = 1'b1;
            if (cmd_on && !c_q.fatal && !c_q.fail) c_d.on = 1'b1;
            if (cmd_off)                           c_d.on = 1'b0;
            if (c_d.fatal || c_d.fail)             c_d.on = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign tx_on = c_q.on;
    assign fail  = c_q.fail;
    assign irq   = c_q.irq;
endmodule

// File: rtl/txcs_top.sv
module txcs_top
    import txcs_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       done_vld,
    input  logic       done_jab,
    input  logic       done_und,
    input  logic       done_maxcoll,
    input  logic       done_irq_req,
    input  logic       stat_wr,
    input  logic       cmd_vld,
    input  logic [1:0] cmd_code,
    input  logic       fifo_ovr,
    output logic [7:0] stat_byte,
    output logic       txc_irq,
    output logic       tx_on,
    output logic       adapter_fail
);
    txcs_evt_t  evt;
    logic [7:0] evt_byte;
    logic       evt_irq, evt_fatal, clr, cmd_on, cmd_off;

    assign evt     = '{jab: done_jab, und: done_und, maxc: done_maxcoll, irq_req: done_irq_req};
    assign clr     = cmd_vld && (cmd_code == CMD_TX_RST || cmd_code == CMD_ALL_RST);
    assign cmd_on  = cmd_vld && (cmd_code == CMD_TX_ON);
    assign cmd_off = cmd_vld && (cmd_code == CMD_TX_OFF);

    txcs_fmt u_fmt (
        .evt       (evt),
        .byte_o    (evt_byte),
        .wants_irq (evt_irq),
        .is_fatal  (evt_fatal)
    );

    txcs_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .push      (done_vld),
        .push_byte (evt_byte),
        .pop       (stat_wr),
        .top_byte  (stat_byte)
    );

    txcs_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .cmd_on    (cmd_on),
        .cmd_off   (cmd_off),
        .evt_vld   (done_vld),
        .evt_irq   (evt_irq),
        .evt_fatal (evt_fatal),
        .fifo_ovr  (fifo_ovr),
        .tx_on     (tx_on),
        .fail      (adapter_fail),
        .irq       (txc_irq)
    );
endmodule

// File: rtl/txcs_chk.sv
module txcs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       done_vld,
    input logic       done_jab,
    input logic       done_und,
    input logic       done_maxcoll,
    input logic       done_irq_req,
    input logic       stat_wr,
    input logic       cmd_vld,
    input logic [1:0] cmd_code,
    input logic       fifo_ovr,
    input logic [7:0] stat_byte,
    input logic       txc_irq,
    input logic       tx_on,
    input logic       adapter_fail
);
    logic rst_cmd;
    assign rst_cmd = cmd_vld && cmd_code[1];

    // R1
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_byte[1:0] == 2'b00);

    // R3
    empty_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_byte != 8'h00) |-> stat_byte[7]);

    // R5
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txc_irq |-> $past(done_vld) && !$past(rst_cmd));

    // R6
    fatal_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_vld && (done_jab || done_und) && !rst_cmd) |=> !tx_on);

    // R7
    fifo_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_ovr && !rst_cmd) |=> adapter_fail && !tx_on);

    // R9
    reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_cmd |=> (stat_byte == 8'h00) && !tx_on && !adapter_fail && !txc_irq);
endmodule

bind txcs_top txcs_chk u_chk (.*);

// File: tb/txcs_top_tb.sv
module txcs_top_tb;
    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       done_vld = 0, done_jab = 0, done_und = 0, done_maxcoll = 0, done_irq_req = 0;
    logic       stat_wr = 0, cmd_vld = 0, fifo_ovr = 0;
    logic [1:0] cmd_code = 2'd0;
    logic [7:0] stat_byte;
    logic       txc_irq, tx_on, adapter_fail;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    txcs_top #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .done_vld(done_vld), .done_jab(done_jab),
        .done_und(done_und), .done_maxcoll(done_maxcoll), .done_irq_req(done_irq_req),
        .stat_wr(stat_wr), .cmd_vld(cmd_vld), .cmd_code(cmd_code), .fifo_ovr(fifo_ovr),
        .stat_byte(stat_byte), .txc_irq(txc_irq), .tx_on(tx_on), .adapter_fail(adapter_fail)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mk(input logic j, u, m, r);
        return {1'b1, r, j, u, m, 3'b000};
    endfunction

    // driver: one completion, optionally with a same-cycle pop; model pushes expected byte
    task automatic complete(input logic j, u, m, r, input logic with_pop);
        @(negedge clk);
        done_vld = 1; done_jab = j; done_und = u; done_maxcoll = m; done_irq_req = r;
        stat_wr = with_pop;
        if (with_pop && exp_q.size() > 0) void'(exp_q.pop_front());
        if (exp_q.size() < DEPTH) exp_q.push_back(mk(j, u, m, r));
        else exp_q[$] = exp_q[$] | 8'h04;
        @(negedge clk);
        done_vld = 0; done_jab = 0; done_und = 0; done_maxcoll = 0; done_irq_req = 0;
        stat_wr = 0;
        chk("R5 irq pulse", {7'd0, txc_irq}, {7'd0, (j | u | m | r)});
    endtask

    // monitor: compare top entry with scoreboard head, then pop it
    task automatic pop_cmp(input string req);
        @(negedge clk);
        chk(req, stat_byte, (exp_q.size() > 0) ? exp_q[0] : 8'h00);
        stat_wr = 1;
        if (exp_q.size() > 0) void'(exp_q.pop_front());
        @(negedge clk);
        stat_wr = 0;
    endtask

    task automatic cmd(input logic [1:0] code);
        @(negedge clk);
        cmd_vld = 1; cmd_code = code;
        if (code[1]) exp_q.delete();
        @(negedge clk);
        cmd_vld = 0;
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset state
        chk("R10 stat", stat_byte, 8'h00);
        chk("R10 on", {7'd0, tx_on}, 8'h00);
        chk("R10 fail", {7'd0, adapter_fail}, 8'h00);
        chk("R10 irq", {7'd0, txc_irq}, 8'h00);

        // R8 enable
        cmd(2'd0);
        chk("R8 enable", {7'd0, tx_on}, 8'h01);

        // R1 R2 R5 format and order
        complete(0, 0, 0, 0, 0);
        complete(0, 0, 0, 1, 0);
        complete(0, 0, 1, 0, 0);
        pop_cmp("R1 clean");
        pop_cmp("R1 irq req");
        pop_cmp("R1 maxcoll");
        // R3 empty, R2 pop on empty ignored
        pop_cmp("R3 empty");
        complete(0, 0, 1, 1, 0);
        pop_cmp("R2 after empty pop");

        // R4 overflow marks newest
        for (int i = 0; i < DEPTH + 2; i++) complete(0, 0, (i % 2) == 1, 0, 0);
        for (int i = 0; i < DEPTH; i++) pop_cmp("R4 overflow");
        pop_cmp("R3 drained");

        // R4 simultaneous pop and push while full
        for (int i = 0; i < DEPTH; i++) complete(0, 0, 0, (i % 2) == 0, 0);
        complete(0, 0, 1, 1, 1);
        for (int i = 0; i < DEPTH; i++) pop_cmp("R4 pop+push full");
        pop_cmp("R3 drained2");

        // R6 jabber fatal
        complete(1, 0, 0, 0, 0);
        chk("R6 jabber off", {7'd0, tx_on}, 8'h00);
        cmd(2'd0);
        chk("R6 enable blocked", {7'd0, tx_on}, 8'h00);
        pop_cmp("R1 jabber byte");
        complete(0, 0, 0, 0, 0);
        cmd(2'd2);
        chk("R9 tx reset empties", stat_byte, 8'h00);
        chk("R9 tx reset off", {7'd0, tx_on}, 8'h00);
        cmd(2'd0);
        chk("R9 enable after reset", {7'd0, tx_on}, 8'h01);

        // R6 underrun, cleared by global reset
        complete(0, 1, 0, 0, 0);
        chk("R6 underrun off", {7'd0, tx_on}, 8'h00);
        chk("R1 underrun byte", stat_byte, 8'h90);
        cmd(2'd3);
        cmd(2'd0);
        chk("R8 global reset recovers", {7'd0, tx_on}, 8'h01);

        // R7 fifo overrun
        @(negedge clk); fifo_ovr = 1;
        @(negedge clk); fifo_ovr = 0;
        chk("R7 fail set", {7'd0, adapter_fail}, 8'h01);
        chk("R7 off", {7'd0, tx_on}, 8'h00);
        cmd(2'd0);
        chk("R7 enable no effect", {7'd0, adapter_fail | tx_on}, 8'h01);
        cmd(2'd1);
        chk("R7 disable keeps fail", {7'd0, adapter_fail}, 8'h01);
        cmd(2'd2);
        chk("R7 reset clears", {7'd0, adapter_fail}, 8'h00);

        // R8 disable
        cmd(2'd0);
        cmd(2'd1);
        chk("R8 disable", {7'd0, tx_on}, 8'h00);

        // R9 reset wins over same-cycle completion
        complete(0, 0, 0, 0, 0);
        @(negedge clk);
        cmd_vld = 1; cmd_code = 2'd2; done_vld = 1; done_irq_req = 1;
        exp_q.delete();
        @(negedge clk);
        cmd_vld = 0; done_vld = 0; done_irq_req = 0;
        chk("R9 same-cycle store", stat_byte, 8'h00);
        chk("R9 same-cycle irq", {7'd0, txc_irq}, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule